// File: doc/BRIEF.md
# ARINC 429 Receive Deserializer

This block takes one serial channel in the ARINC 429 style and turns each valid word into a parallel value that a host reads as two 16-bit halves. The line arrives as two logic-level inputs, already translated from the bus. One input marks the high state and the other marks the low state. When neither or both are set, the line is null. The block samples the line ten times per bit period and recovers each bit from its return-to-zero pulse. It collects the bits of a word and computes the word's parity status.

In 32-bit mode the block can compare the source/destination bits of a word with a code that the host sets, and it keeps only matching words. A word that is complete and accepted goes into a holding register and raises a ready flag. The host reads either half by setting a select line and raising a read enable. A read of the second half clears the flag. Two configuration inputs choose the bit rate (clock/10 or clock/80) and the word length (32 or 25 bits).

Top module: `arinc_rx_deser`

## Requirements
- R1: While `rst_n` is low at a clock edge, `word_ready` goes to 0 and any partly collected word is dropped. Configuration inputs are not stored by the block, so reset does not touch them.
- R2: In 32-bit mode (`len_short`=0), the 32nd bit of a word completes it. An accepted word sets `word_ready` to 1 within a few clock cycles.
- R3: A bit is recognised when two consecutive samples agree on the high or the low state, and high means 1. Only one bit is taken per pulse. A pulse that lasts a single sample is ignored.
- R4: A run of null samples of at least two bit times (20 samples) discards a partly received word, and counting starts again from bit 1.
- R5: With `rate_slow`=0 the line is sampled on every clock, so one bit lasts 10 clocks. With `rate_slow`=1 it is sampled every 8th clock, so one bit lasts 80 clocks.
- R6: In 25-bit mode (`len_short`=1), the 25th bit completes the word. Half 1 is {7'b0, parity status, bits 8..1} and half 2 is {bits 24..10, bit 9}, with the higher-numbered bit on the higher index.
- R7: The parity status is taken over all bits of the word. It is 0 when the number of ones is odd and 1 when it is even, and it appears on half-1 bit [8].
- R8: With `sd_enable`=1 in 32-bit mode, a word is latched only if bit 9 equals `sd_x` and bit 10 equals `sd_y`. Any other word leaves the holding register and `word_ready` unchanged. With `sd_enable`=0, or in 25-bit mode, no such check is made.
- R9: In 32-bit mode, half 1 (`rd_sel`=0) carries bits 8..1 on [7:0] (bit 1 on [0]), parity status on [8], bit 30 on [9], bit 31 on [10], bit 9 on [11], bit 10 on [12], bit 11 on [13], bit 12 on [14] and bit 13 on [15].
- R10: In 32-bit mode, half 2 (`rd_sel`=1) carries bit 29 on [15], bit 28 on [14] and bits 27..14 on [13:0] (bit 14 on [0]).
- R11: A new accepted word replaces an unread word in the holding register.
- R12: `rd_data` shows the selected half while `rd_en` is 1 and is 0 otherwise. Either half may be read in any order and as often as needed. A clock edge with `rd_en`=1 and `rd_sel`=1 clears `word_ready`, unless a word is latched at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, ten times the fast bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_hi | input | 1 | Line is in the high state |
| line_lo | input | 1 | Line is in the low state |
| rate_slow | input | 1 | 1: sample every 8th clock (bit rate clock/80) |
| len_short | input | 1 | 1: 25-bit words, 0: 32-bit words |
| sd_enable | input | 1 | Enables the source/destination filter |
| sd_x | input | 1 | Required value of bit 9 |
| sd_y | input | 1 | Required value of bit 10 |
| rd_sel | input | 1 | Read half select (0: half 1, 1: half 2) |
| rd_en | input | 1 | Read enable strobe |
| rd_data | output | 16 | Selected half of the held word |
| word_ready | output | 1 | An accepted word is waiting to be read |

## Verification
The assertions take the following for granted about the inputs:
- The line inputs and all control inputs are synchronous to `clk`.
- A bit pulse and the null that follows it each last longer than one sample.
- The word length does not change in the middle of a word.

The bench drives every input one time unit after a rising edge. Each pulse lasts five samples and is followed by five null samples, and every word ends with a 30-sample null gap. Configuration changes only while the line is idle. In this way the assumptions hold for all stimulus except the deliberate single-sample glitch.

// File: rtl/arx_pkg.sv
package arx_pkg;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        LS_NULL = 2'd0,
        LS_HI   = 2'd1,
        LS_LO   = 2'd2
    } line_e;
endpackage

// File: rtl/arx_sampler.sv
module arx_sampler
    import arx_pkg::*;
#(
    parameter int OVERSAMPLE = 10,
    parameter int SLOW_DIV   = 8,
    parameter int GAP_BITS   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hi,
    input  logic line_lo,
    input  logic rate_slow,
    output logic bit_stb,
    output logic bit_val,
    output logic gap_stb
);
    localparam int GAP_SAMPLES = GAP_BITS * OVERSAMPLE;
    localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int RW = $clog2(GAP_SAMPLES + 1);

    typedef struct packed {
        logic [PW-1:0] presc;
        line_e         prev;
        logic          armed;
        logic [RW-1:0] run;
        logic          bit_stb;
        logic          bit_val;
        logic          gap_stb;
    } smp_t;

    smp_t  smp_q, smp_d;
    line_e cls;
    logic  tick;

    always_comb begin
        smp_d         = smp_q;
        smp_d.bit_stb = 1'b0;
        smp_d.gap_stb = 1'b0;
        tick          = !rate_slow || (smp_q.presc == PW'(SLOW_DIV - 1));
        if (rate_slow) smp_d.presc = tick ? '0 : smp_q.presc + 1'b1;
        else           smp_d.presc = '0;

        if (line_hi && !line_lo)      cls = LS_HI;
        else if (line_lo && !line_hi) cls = LS_LO;
        else                          cls = LS_NULL;

        if (tick) begin
            smp_d.prev = cls;
            if (cls == LS_NULL) begin
                smp_d.armed = 1'b1;
                if (smp_q.run != RW'(GAP_SAMPLES)) smp_d.run = smp_q.run + 1'b1;
                if (smp_q.run == RW'(GAP_SAMPLES - 1)) smp_d.gap_stb = 1'b1;
            end else begin
                smp_d.run = '0;
                if (cls == smp_q.prev && smp_q.armed) begin
                    smp_d.bit_stb = 1'b1;
                    smp_d.bit_val = (cls == LS_HI);
                    smp_d.armed   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q       <= '0;
            smp_q.prev  <= LS_NULL;
            smp_q.run   <= RW'(GAP_SAMPLES);
        end else begin
            smp_q <= smp_d;
        end
    end

    assign bit_stb = smp_q.bit_stb;
    assign bit_val = smp_q.bit_val;
    assign gap_stb = smp_q.gap_stb;

    p_one_bit_per_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    p_gap_excludes_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_stb && gap_stb));
endmodule

// File: rtl/arx_shifter.sv
module arx_shifter #(
    parameter int LONG_LEN  = 32,
    parameter int SHORT_LEN = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic                gap_stb,
    input  logic                len_short,
    output logic                done,
    output logic [LONG_LEN-1:0] word,
    output logic                par_stat,
    output logic                word_short
);
    localparam int CW = $clog2(LONG_LEN);

    typedef struct packed {
        logic [LONG_LEN-1:0] bits;
        logic [CW-1:0]       cnt;
        logic                par;
        logic                done;
        logic [LONG_LEN-1:0] word;
        logic                par_stat;
        logic                word_short;
    } shf_t;

    shf_t                shf_q, shf_d;
    logic [LONG_LEN-1:0] merged;
    logic                last;

    always_comb begin
        shf_d      = shf_q;
        shf_d.done = 1'b0;
        merged     = shf_q.bits;
        merged[shf_q.cnt] = bit_val;
        last = len_short ? (shf_q.cnt == CW'(SHORT_LEN - 1))
                         : (shf_q.cnt == CW'(LONG_LEN - 1));
        if (bit_stb) begin
            if (last) begin
                shf_d.done       = 1'b1;
                shf_d.word       = merged;
                shf_d.par_stat   = ~(shf_q.par ^ bit_val);
                shf_d.word_short = len_short;
                shf_d.bits       = '0;
                shf_d.cnt        = '0;
                shf_d.par        = 1'b0;
            end else begin
                shf_d.bits = merged;
                shf_d.cnt  = shf_q.cnt + 1'b1;
                shf_d.par  = shf_q.par ^ bit_val;
            end
        end else if (gap_stb) begin
            shf_d.bits = '0;
            shf_d.cnt  = '0;
            shf_d.par  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign done       = shf_q.done;
    assign word       = shf_q.word;
    assign par_stat   = shf_q.par_stat;
    assign word_short = shf_q.word_short;

    p_done_follows_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_stb));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/arx_hold.sv
module arx_hold
    import arx_pkg::*;
#(
    parameter int LONG_LEN = 32,
    parameter int SD_X_IDX = 8,
    parameter int SD_Y_IDX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [LONG_LEN-1:0] word,
    input  logic                par_stat,
    input  logic                word_short,
    input  logic                sd_enable,
    input  logic                sd_x,
    input  logic                sd_y,
    input  logic                rd_sel,
    input  logic                rd_en,
    output logic [HALF_W-1:0]   rd_data,
    output logic                word_ready
);
    typedef struct packed {
        logic [LONG_LEN-1:0] bits;
        logic                par;
        logic                short_fmt;
        logic                ready;
    } hld_t;

    hld_t              hld_q, hld_d;
    logic              sd_ok;
    logic [HALF_W-1:0] half1, half2;

    always_comb begin
        hld_d = hld_q;
        sd_ok = word_short || !sd_enable ||
                (word[SD_X_IDX] == sd_x && word[SD_Y_IDX] == sd_y);
        if (done && sd_ok) begin
            hld_d.bits      = word;
            hld_d.par       = par_stat;
            hld_d.short_fmt = word_short;
            hld_d.ready     = 1'b1;
        end else if (rd_en && rd_sel) begin
            hld_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hld_q <= '0;
        else        hld_q <= hld_d;
    end

    always_comb begin
        half1 = '0;
        half2 = '0;
        half1[7:0] = hld_q.bits[7:0];
        half1[8]   = hld_q.par;
        if (hld_q.short_fmt) begin
            half2[HALF_W-1:1] = hld_q.bits[23:9];
            half2[0]          = hld_q.bits[8];
        end else begin
            half1[9]  = hld_q.bits[29];
            half1[10] = hld_q.bits[30];
            half1[11] = hld_q.bits[8];
            half1[12] = hld_q.bits[9];
            half1[13] = hld_q.bits[10];
            half1[14] = hld_q.bits[11];
            half1[15] = hld_q.bits[12];
            half2[15]   = hld_q.bits[28];
            half2[14]   = hld_q.bits[27];
            half2[13:0] = hld_q.bits[26:13];
        end
        if (!rd_en)      rd_data = '0;
        else if (rd_sel) rd_data = half2;
        else             rd_data = half1;
    end

    assign word_ready = hld_q.ready;

    p_ready_from_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_ready) |-> $past(done));

    p_ready_fall_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_ready) |-> $past(rd_en && rd_sel));

    p_filter_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !word_short && sd_enable && word[SD_X_IDX] != sd_x && !word_ready)
        |=> !word_ready);
endmodule

// File: rtl/arinc_rx_deser.sv
module arinc_rx_deser (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        rate_slow,
    input  logic        len_short,
    input  logic        sd_enable,
    input  logic        sd_x,
    input  logic        sd_y,
    input  logic        rd_sel,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        word_ready
);
    localparam int LONG_LEN  = 32;
    localparam int SHORT_LEN = 25;

    logic                bit_stb, bit_val, gap_stb;
    logic                done, par_stat, word_short;
    logic [LONG_LEN-1:0] word;

    arx_sampler #(
        .OVERSAMPLE (10),
        .SLOW_DIV   (8),
        .GAP_BITS   (2)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_hi   (line_hi),
        .line_lo   (line_lo),
        .rate_slow (rate_slow),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .gap_stb   (gap_stb)
    );

    arx_shifter #(
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .gap_stb    (gap_stb),
        .len_short  (len_short),
        .done       (done),
        .word       (word),
        .par_stat   (par_stat),
        .word_short (word_short)
    );

    arx_hold #(
        .LONG_LEN (LONG_LEN),
        .SD_X_IDX (8),
        .SD_Y_IDX (9)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .word       (word),
        .par_stat   (par_stat),
        .word_short (word_short),
        .sd_enable  (sd_enable),
        .sd_x       (sd_x),
        .sd_y       (sd_y),
        .rd_sel     (rd_sel),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .word_ready (word_ready)
    );
endmodule

// File: tb/arinc_rx_deser_test.sv
module arinc_rx_deser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_hi = 1'b0, line_lo = 1'b0;
    logic        rate_slow = 1'b0, len_short = 1'b0;
    logic        sd_enable = 1'b0, sd_x = 1'b0, sd_y = 1'b0;
    logic        rd_sel = 1'b0, rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        word_ready;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    arinc_rx_deser uut (
        .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
        .rate_slow(rate_slow), .len_short(len_short), .sd_enable(sd_enable),
        .sd_x(sd_x), .sd_y(sd_y), .rd_sel(rd_sel), .rd_en(rd_en),
        .rd_data(rd_data), .word_ready(word_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_half(input logic [31:0] w, input bit short, input bit sel);
        logic [31:0] m;
        logic [15:0] h;
        logic        p;
        m = short ? (w & 32'h01FF_FFFF) : w;
        p = ($countones(m) % 2) == 0;
        h = '0;
        if (!sel) begin
            h[7:0] = m[7:0];
            h[8]   = p;
            if (!short) begin
                h[10:9]  = {m[30], m[29]};
                h[12:11] = {m[9], m[8]};
                h[13]    = m[10];
                h[15:14] = {m[12], m[11]};
            end
        end else if (short) begin
            h = {m[23:9], m[8]};
        end else begin
            h = {m[28], m[27], m[26:13]};
        end
        return h;
    endfunction

    task automatic sample(input logic h, input logic l);
        line_hi = h;
        line_lo = l;
        repeat (rate_slow ? 8 : 1) @(posedge clk);
        #1;
    endtask

    task automatic send_raw(input logic [31:0] w, input int nbits, input int glitch_at);
        for (int k = 0; k < nbits; k++) begin
            for (int s = 0; s < 5; s++) sample(w[k], !w[k]);
            for (int s = 0; s < 5; s++) sample(1'b0, 1'b0);
            if (k == glitch_at) begin
                for (int s = 0; s < 3; s++) sample(1'b0, 1'b0);
                sample(1'b1, 1'b0);
                for (int s = 0; s < 3; s++) sample(1'b0, 1'b0);
            end
        end
        for (int s = 0; s < 30; s++) sample(1'b0, 1'b0);
    endtask

    task automatic read_half(input bit sel, output logic [15:0] d);
        rd_sel = sel;
        rd_en  = 1'b1;
        #1;
        d = rd_data;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic verify_word(input string tag, input logic [31:0] w, input bit short);
        logic [15:0] d;
        read_half(1'b0, d);
        check({tag, " half1"}, {16'h0, d}, {16'h0, exp_half(w, short, 1'b0)});
        read_half(1'b1, d);
        check({tag, " half2"}, {16'h0, d}, {16'h0, exp_half(w, short, 1'b1)});
        check({tag, " ready cleared"}, {31'h0, word_ready}, 32'h0);
    endtask

    task automatic t_reset;
        check("R1 ready after reset", {31'h0, word_ready}, 32'h0);
        check("R12 data idle without enable", {16'h0, rd_data}, 32'h0);
    endtask

    task automatic t_basic32;
        logic [15:0] d;
        logic [31:0] w = 32'hA5C3_1E69;
        send_raw(w, 32, -1);
        check("R2 ready after 32 bits", {31'h0, word_ready}, 32'h1);
        read_half(1'b0, d);
        check("R9 half1 layout", {16'h0, d}, {16'h0, exp_half(w, 1'b0, 1'b0)});
        read_half(1'b0, d);
        check("R12 half1 repeat", {16'h0, d}, {16'h0, exp_half(w, 1'b0, 1'b0)});
        check("R12 half1 read keeps ready", {31'h0, word_ready}, 32'h1);
        read_half(1'b1, d);
        check("R10 half2 layout", {16'h0, d}, {16'h0, exp_half(w, 1'b0, 1'b1)});
        check("R12 half2 read clears ready", {31'h0, word_ready}, 32'h0);
        read_half(1'b1, d);
        check("R12 half2 reread", {16'h0, d}, {16'h0, exp_half(w, 1'b0, 1'b1)});
    endtask

    task automatic t_parity;
        logic [15:0] d;
        send_raw(32'h0000_0001, 32, -1);
        read_half(1'b0, d);
        check("R7 odd ones status 0", {31'h0, d[8]}, 32'h0);
        read_half(1'b1, d);
        send_raw(32'h8000_0001, 32, -1);
        read_half(1'b0, d);
        check("R7 even ones status 1", {31'h0, d[8]}, 32'h1);
        read_half(1'b1, d);
    endtask

    task automatic t_filter;
        logic [15:0] d;
        logic [31:0] good = 32'h1234_0155;
        logic [31:0] bad  = 32'h4321_0255;
        sd_enable = 1'b1; sd_x = 1'b1; sd_y = 1'b0;
        send_raw(good, 32, -1);
        check("R8 match accepted", {31'h0, word_ready}, 32'h1);
        verify_word("R8 match", good, 1'b0);
        send_raw(bad, 32, -1);
        check("R8 mismatch dropped", {31'h0, word_ready}, 32'h0);
        read_half(1'b1, d);
        check("R8 holding kept", {16'h0, d}, {16'h0, exp_half(good, 1'b0, 1'b1)});
        sd_enable = 1'b0;
        send_raw(bad, 32, -1);
        check("R8 filter off accepts", {31'h0, word_ready}, 32'h1);
        verify_word("R8 filter off", bad, 1'b0);
    endtask

    task automatic t_short;
        logic [31:0] w = 32'h00AB_CE3C;
        len_short = 1'b1;
        sd_enable = 1'b1; sd_x = 1'b1; sd_y = 1'b1;
        send_raw(w, 25, -1);
        check("R8 R6 no filter in 25-bit", {31'h0, word_ready}, 32'h1);
        verify_word("R6 short", w, 1'b1);
        sd_enable = 1'b0;
        len_short = 1'b0;
    endtask

    task automatic t_partial;
        logic [31:0] w = 32'h5A5A_F00F;
        send_raw(32'h0000_03FF, 10, -1);
        check("R4 partial not latched", {31'h0, word_ready}, 32'h0);
        send_raw(w, 32, -1);
        check("R4 word after gap", {31'h0, word_ready}, 32'h1);
        verify_word("R4 clean restart", w, 1'b0);
    endtask

    task automatic t_glitch;
        logic [31:0] w = 32'hC001_D00D;
        send_raw(w, 32, 5);
        check("R3 glitch ignored ready", {31'h0, word_ready}, 32'h1);
        verify_word("R3 glitch", w, 1'b0);
    endtask

    task automatic t_slow;
        logic [31:0] w = 32'h3C96_A51E;
        rate_slow = 1'b1;
        send_raw(w, 32, -1);
        check("R5 slow rate ready", {31'h0, word_ready}, 32'h1);
        verify_word("R5 slow", w, 1'b0);
        rate_slow = 1'b0;
    endtask

    task automatic t_overwrite;
        logic [31:0] w1 = 32'h1111_2222;
        logic [31:0] w2 = 32'h7777_8888;
        send_raw(w1, 32, -1);
        send_raw(w2, 32, -1);
        check("R11 still ready", {31'h0, word_ready}, 32'h1);
        verify_word("R11 newest word", w2, 1'b0);
    endtask

    task automatic t_reset_clears;
        send_raw(32'h0F0F_0F0F, 32, -1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        check("R1 reset clears ready", {31'h0, word_ready}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_basic32();
        t_parity();
        t_filter();
        t_short();
        t_partial();
        t_glitch();
        t_slow();
        t_overwrite();
        t_reset_clears();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule